// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of month, month, two-digit year, a binary weekday and a century byte. A single-cycle pulse on the tick input, expected once per second, advances the time by one second. All carries follow from that advance: into minutes, hours, day, month, year and century. The day carry takes account of month lengths and leap years. The hour byte runs in either 24-hour or 12-hour form, chosen by its top bit.

A second eight-byte bank holds an alarm time. Each of its first five bytes carries its own compare-enable in bit 7. On every tick the alarm is compared against the freshly advanced time. A full match of all enabled fields sets a sticky flag, and that flag drives an interrupt output when the interrupt enable is set. Software reaches both banks, the flag and the enable through a byte-wide register port. Writes through that port are synchronous and reads are combinational.

Top module: `bcd_rtc_alarm`

## Requirements
- R1: After reset the time bank reads sec 00, min 00, hour 80 (24-hour mode, hour 0), day 01, month 01, year 00, weekday 00, century 20; every alarm byte, the status register and the interrupt enable read 00; alarm_flag and irq are 0.
- R2: Addresses 0x00-0x07 hold the alarm bank and 0x08-0x0F the time bank, each ordered offset 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year, 6 weekday, 7 century; 0x10 is status (flag at bit 5) and 0x11 interrupt enable (bit 5). Written bytes read back unchanged, except the time weekday, which keeps only bits 2:0 and reads zero-extended.
- R3: Each tick advances seconds by one in BCD (09 to 10), seconds and minutes wrap from 59 to 00 and carry onward, and with no tick and no write the time bank holds its value.
- R4: With hour bit 7 set (24-hour mode), hour bits 5:0 count 00 to 23 in BCD; 23 wraps to 00, bit 7 is kept, and the day advances.
- R5: With hour bit 7 clear (12-hour mode), bit 5 is PM and bits 4:0 count 01 to 12 in BCD; 11 AM becomes 12 PM (0x32), 12 becomes 01 with PM kept, and 11 PM becomes 12 AM (0x12) with a day advance.
- R6: The day wraps to 01 and the month advances after day 30 for months 04, 06, 09 and 11, after 29 for month 02 when the two-digit year is divisible by 4, after 28 for month 02 otherwise, and after 31 for all other months; month 12 wraps to 01 and advances the year.
- R7: When the year rolls from 99 to 00 the century byte increments in BCD.
- R8: The weekday increments modulo 7 (6 wraps to 0) each time the day of month advances.
- R9: On each tick, the alarm fires when at least one of alarm bytes 0-4 has bit 7 set and every enabled field equals the advanced time with bit 7 ignored; the hour field compares bits 5:0 only. Disabled fields are ignored, alarm bytes 6 and 7 never take part, and time writes without a tick never evaluate the alarm.
- R10: An alarm match sets status bit 5, which then stays set; it clears only on a status write with bit 5 equal to 0, a written 1 has no effect, and a match in the same cycle as a clearing write leaves the flag set.
- R11: irq is 1 exactly when the status flag is set and interrupt enable bit 5 is 1.
- R12: A write into the time bank in the same cycle as a tick takes effect and that tick is dropped for the whole bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle advance pulse, once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| alarm_flag | output | 1 | Sticky alarm match flag |
| irq | output | 1 | Interrupt: flag gated by the enable bit |

## Verification
The bench builds the block with its default parameters: a 5-bit address, the alarm bank at 0x00, the time bank at 0x08, status and enable at 0x10 and 0x11, and the 12-hour variant of the hour counter generated in. That variant makes both hour modes reachable from one build, so the AM/PM transitions are checked next to the 24-hour wrap. A table of preset-and-advance vectors walks every carry chain, up to the century, through short and long months and leap and common Februaries. Directed sequences then cover the alarm's enable masking, the sticky flag and its clear priority, the interrupt gating and the write-over-tick collision.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

   localparam int BYTE_W     = 8;
   localparam int NUM_FIELDS = 8;
   localparam int NUM_CMP    = 5;

   typedef enum logic [2:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_DAY  = 3'd3,
      F_MON  = 3'd4,
      F_YEAR = 3'd5,
      F_WDAY = 3'd6,
      F_CENT = 3'd7
   } field_e;

   // two-digit BCD increment
   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return v + 8'd1;
   endfunction

   // full year divisible by 4 reduces to the two BCD digits
   function automatic logic leap_yy(input logic [7:0] yy);
      if (yy[4]) return (yy[3:0] == 4'h2) || (yy[3:0] == 4'h6);
      else       return (yy[3:0] == 4'h0) || (yy[3:0] == 4'h4) || (yy[3:0] == 4'h8);
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yy);
      case (mon)
         8'h02:                      return leap_yy(yy) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcdcal_wrap_cnt.sv
module bcdcal_wrap_cnt #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic         inc,
   output logic [W-1:0] nxt,
   output logic         carry
);
   initial begin
      assert (W == 8) else $error("bcdcal_wrap_cnt: W must be 8");
   end

   always_comb begin
      carry = inc && (cur >= hi);
      if (!inc)      nxt = cur;
      else if (carry) nxt = lo;
      else            nxt = bcdcal_pkg::bcd_inc8(cur);
   end
endmodule

// File: rtl/bcdcal_hour_adv.sv
module bcdcal_hour_adv #(
   parameter bit SUPPORT_12H = 1'b1
) (
   input  logic [7:0] cur,
   input  logic       inc,
   output logic [7:0] nxt,
   output logic       carry
);
   logic [5:0] h24_nxt;
   logic       h24_wrap;

   always_comb begin
      h24_wrap = (cur[5:0] >= 6'h23);
      if (h24_wrap)              h24_nxt = 6'h00;
      else if (cur[3:0] >= 4'd9) h24_nxt = {cur[5:4] + 2'd1, 4'd0};
      else                       h24_nxt = cur[5:0] + 6'd1;
   end

   generate
      if (SUPPORT_12H) begin : g_dual
         logic [4:0] h12_nxt;
         logic       pm_nxt;
         logic       h12_wrap;
         always_comb begin
            pm_nxt   = cur[5];
            h12_wrap = 1'b0;
            if (cur[4:0] == 5'h11) begin
               h12_nxt  = 5'h12;
               pm_nxt   = ~cur[5];
               h12_wrap = cur[5];
            end else if (cur[4:0] >= 5'h12) begin
               h12_nxt = 5'h01;
            end else if (cur[3:0] >= 4'd9) begin
               h12_nxt = {cur[4] + 1'b1, 4'd0};
            end else begin
               h12_nxt = cur[4:0] + 5'd1;
            end
         end
         always_comb begin
            if (!inc) begin
               nxt   = cur;
               carry = 1'b0;
            end else if (cur[7]) begin
               nxt   = {cur[7:6], h24_nxt};
               carry = h24_wrap;
            end else begin
               nxt   = {cur[7:6], pm_nxt, h12_nxt};
               carry = h12_wrap;
            end
         end
      end else begin : g_24only
         always_comb begin
            nxt   = inc ? {cur[7:6], h24_nxt} : cur;
            carry = inc && h24_wrap;
         end
      end
   endgenerate
endmodule

// File: rtl/bcdcal_alarm_cmp.sv
module bcdcal_alarm_cmp #(
   parameter int NUM_CMP  = 5,
   parameter int HOUR_IDX = 2
) (
   input  logic [NUM_CMP*8-1:0] alarm_vec,
   input  logic [NUM_CMP*8-1:0] time_vec,
   input  logic                 evt,
   output logic                 hit
);
   initial begin
      assert (NUM_CMP >= 1 && NUM_CMP <= 8) else $error("bcdcal_alarm_cmp: NUM_CMP out of range");
      assert (HOUR_IDX < NUM_CMP) else $error("bcdcal_alarm_cmp: HOUR_IDX out of range");
   end

   logic [NUM_CMP-1:0] en;
   logic [NUM_CMP-1:0] eq;

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_fld
         localparam logic [7:0] MASK = (i == HOUR_IDX) ? 8'h3F : 8'h7F;
         assign en[i] = alarm_vec[i*8+7];
         assign eq[i] = (((alarm_vec[i*8 +: 8] ^ time_vec[i*8 +: 8]) & MASK) == 8'h00);
      end
   endgenerate

   assign hit = evt && (|en) && (&(eq | ~en));
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm #(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned ALARM_BASE    = 0,
   parameter int unsigned TIME_BASE     = 8,
   parameter int unsigned STATUS_ADDR   = 16,
   parameter int unsigned INTEN_ADDR    = 17,
   parameter bit          SUPPORT_12H   = 1'b1,
   parameter logic [7:0]  RESET_CENTURY = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              alarm_flag,
   output logic              irq
);
   import bcdcal_pkg::*;

   localparam int FLAG_BIT = 5;
   localparam int BLK_W    = ADDR_W - 3;
   localparam logic [BLK_W-1:0]  ALARM_BLK = ALARM_BASE[ADDR_W-1:3];
   localparam logic [BLK_W-1:0]  TIME_BLK  = TIME_BASE[ADDR_W-1:3];
   localparam logic [ADDR_W-1:0] STAT_A    = STATUS_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] IEN_A     = INTEN_ADDR[ADDR_W-1:0];

   initial begin
      assert (ADDR_W >= 5) else $error("bcd_rtc_alarm: ADDR_W too small");
      assert (ALARM_BASE % 8 == 0 && TIME_BASE % 8 == 0) else $error("bcd_rtc_alarm: banks must be 8-aligned");
      assert (ALARM_BASE != TIME_BASE) else $error("bcd_rtc_alarm: banks overlap");
      assert (STATUS_ADDR / 8 != ALARM_BASE / 8 && STATUS_ADDR / 8 != TIME_BASE / 8)
         else $error("bcd_rtc_alarm: status inside a bank");
      assert (INTEN_ADDR / 8 != ALARM_BASE / 8 && INTEN_ADDR / 8 != TIME_BASE / 8)
         else $error("bcd_rtc_alarm: enable inside a bank");
      assert (STATUS_ADDR != INTEN_ADDR) else $error("bcd_rtc_alarm: status and enable collide");
      assert (STATUS_ADDR < (1 << ADDR_W) && INTEN_ADDR < (1 << ADDR_W) && TIME_BASE < (1 << ADDR_W))
         else $error("bcd_rtc_alarm: address out of range");
   end

   function automatic logic [7:0] field_reset(input int idx);
      case (idx)
         int'(F_HOUR): return 8'h80;
         int'(F_DAY):  return 8'h01;
         int'(F_MON):  return 8'h01;
         int'(F_CENT): return RESET_CENTURY;
         default:      return 8'h00;
      endcase
   endfunction

   // ---------------- decode
   logic [2:0] idx;
   logic       hit_alarm_blk, hit_time_blk;
   logic       wr_alarm, wr_time, wr_stat, wr_ien;

   assign idx           = reg_addr[2:0];
   assign hit_alarm_blk = (reg_addr[ADDR_W-1:3] == ALARM_BLK);
   assign hit_time_blk  = (reg_addr[ADDR_W-1:3] == TIME_BLK);
   assign wr_alarm      = reg_we && hit_alarm_blk;
   assign wr_time       = reg_we && hit_time_blk;
   assign wr_stat       = reg_we && (reg_addr == STAT_A);
   assign wr_ien        = reg_we && (reg_addr == IEN_A);

   // ---------------- storage
   logic [7:0] tbank [NUM_FIELDS];
   logic [7:0] abank [NUM_FIELDS];
   logic [7:0] tnext [NUM_FIELDS];
   logic       flag_q, ien_q;

   // ---------------- advance chain
   logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;
   logic [7:0] day_hi;
   logic       adv;

   assign day_hi = last_day(tbank[F_MON], tbank[F_YEAR]);
   assign adv    = tick && !wr_time;

   bcdcal_wrap_cnt #(.W(8)) u_sec (
      .cur(tbank[F_SEC]), .lo(8'h00), .hi(8'h59), .inc(1'b1),
      .nxt(tnext[F_SEC]), .carry(c_sec));
   bcdcal_wrap_cnt #(.W(8)) u_min (
      .cur(tbank[F_MIN]), .lo(8'h00), .hi(8'h59), .inc(c_sec),
      .nxt(tnext[F_MIN]), .carry(c_min));
   bcdcal_hour_adv #(.SUPPORT_12H(SUPPORT_12H)) u_hour (
      .cur(tbank[F_HOUR]), .inc(c_min),
      .nxt(tnext[F_HOUR]), .carry(c_hr));
   bcdcal_wrap_cnt #(.W(8)) u_day (
      .cur(tbank[F_DAY]), .lo(8'h01), .hi(day_hi), .inc(c_hr),
      .nxt(tnext[F_DAY]), .carry(c_day));
   bcdcal_wrap_cnt #(.W(8)) u_mon (
      .cur(tbank[F_MON]), .lo(8'h01), .hi(8'h12), .inc(c_day),
      .nxt(tnext[F_MON]), .carry(c_mon));
   bcdcal_wrap_cnt #(.W(8)) u_year (
      .cur(tbank[F_YEAR]), .lo(8'h00), .hi(8'h99), .inc(c_mon),
      .nxt(tnext[F_YEAR]), .carry(c_yr));

   always_comb begin
      if (!c_hr)                      tnext[F_WDAY] = tbank[F_WDAY];
      else if (tbank[F_WDAY] >= 8'h06) tnext[F_WDAY] = 8'h00;
      else                            tnext[F_WDAY] = tbank[F_WDAY] + 8'h01;
      tnext[F_CENT] = c_yr ? bcd_inc8(tbank[F_CENT]) : tbank[F_CENT];
   end

   // ---------------- alarm compare against advanced time
   logic [NUM_CMP*8-1:0] a_vec, t_vec;
   logic                 match;

   generate
      for (genvar f = 0; f < NUM_CMP; f++) begin : g_pack
         assign a_vec[f*8 +: 8] = abank[f];
         assign t_vec[f*8 +: 8] = tnext[f];
      end
   endgenerate

   bcdcal_alarm_cmp #(.NUM_CMP(NUM_CMP), .HOUR_IDX(int'(F_HOUR))) u_cmp (
      .alarm_vec(a_vec), .time_vec(t_vec), .evt(adv), .hit(match));

   // ---------------- sequential state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) tbank[i] <= field_reset(i);
      end else if (wr_time) begin
         if (idx == F_WDAY) tbank[idx] <= {5'b0, reg_wdata[2:0]};
         else               tbank[idx] <= reg_wdata;
      end else if (tick) begin
         for (int i = 0; i < NUM_FIELDS; i++) tbank[i] <= tnext[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) abank[i] <= 8'h00;
      end else if (wr_alarm) begin
         abank[idx] <= reg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (match)                                flag_q <= 1'b1;
         else if (wr_stat && !reg_wdata[FLAG_BIT]) flag_q <= 1'b0;
         if (wr_ien) ien_q <= reg_wdata[FLAG_BIT];
      end
   end

   // ---------------- read path and outputs
   always_comb begin
      reg_rdata = 8'h00;
      if (hit_alarm_blk)          reg_rdata = abank[idx];
      else if (hit_time_blk)      reg_rdata = tbank[idx];
      else if (reg_addr == STAT_A) reg_rdata[FLAG_BIT] = flag_q;
      else if (reg_addr == IEN_A)  reg_rdata[FLAG_BIT] = ien_q;
   end

   assign alarm_flag = flag_q;
   assign irq        = flag_q && ien_q;

   // ---------------- assertions
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reg_we) |=> ($stable(tbank[F_SEC]) && $stable(tbank[F_MIN]) &&
                              $stable(tbank[F_HOUR]) && $stable(tbank[F_DAY])));

   a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !reg_we && tbank[F_SEC] == 8'h59) |=> (tbank[F_SEC] == 8'h00));

   a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(tick));

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !(reg_we && reg_addr == STAT_A && !reg_wdata[FLAG_BIT])) |=> alarm_flag);

   a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(tick) || $past(reg_we)));

   a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reg_we && reg_addr == {TIME_BLK, 3'd0}) |=> (tbank[F_SEC] == $past(reg_wdata)));

endmodule

// File: tb/bcd_rtc_alarm_tb_top.sv
module bcd_rtc_alarm_tb_top;
   localparam int AW = 5;
   localparam int TB = 8;       // time bank base
   localparam int AB = 0;       // alarm bank base
   localparam int SR = 16;      // status
   localparam int IE = 17;      // interrupt enable
   localparam int NV = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [7:0]    reg_wdata = 8'h00;
   logic [7:0]    reg_rdata;
   logic          alarm_flag, irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;  // 125 MHz

   bcd_rtc_alarm dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alarm_flag(alarm_flag), .irq(irq));

   // preset bytes (sec min hour day mon year wday cent) _ expected after one tick
   localparam logic [127:0] VEC [0:NV-1] = '{
      128'h00008001_01000020_01008001_01000020, // R3 plain second
      128'h59008001_01000020_00018001_01000020, // R3 second wrap
      128'h59598001_01000020_00008101_01000020, // R3 minute wrap
      128'h09098901_01000020_10098901_01000020, // R3 BCD digit carry
      128'h5959A331_01240320_00008001_02240420, // R4 R6 end of January
      128'h5959A328_02240620_00008029_02240020, // R6 R8 leap Feb 28, weekday 6 wraps
      128'h5959A329_02240020_00008001_03240120, // R6 leap Feb 29
      128'h5959A328_02230220_00008001_03230320, // R6 common Feb 28
      128'h5959A328_02920019_00008029_02920119, // R6 leap in 1992
      128'h5959A330_04250120_00008001_05250220, // R6 30-day month
      128'h5959A330_05250120_00008031_05250220, // R6 31-day month
      128'h5959A331_12990519_00008001_01000620, // R7 century roll
      128'h59591101_01000020_00003201_01000020, // R5 11 AM to 12 PM
      128'h59593201_01000020_00002101_01000020, // R5 12 PM to 1 PM
      128'h59593115_06240220_00001216_06240320, // R5 11 PM to 12 AM, day advance
      128'h59591201_01000020_00000101_01000020, // R5 12 AM to 1 AM
      128'h59599901_01000020_0000A001_01000020, // R4 19 to 20 in 24-hour
      128'h5959A331_12240320_00008001_01250420  // R6 R7 year advance, no century
   };
   localparam int VREQ [0:NV-1] = '{3, 3, 3, 3, 4, 6, 6, 6, 6, 6, 6, 7, 5, 5, 5, 5, 4, 6};

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic clear_alarm();
      for (int i = 0; i < 8; i++) wr(AB + i, 8'h00);
      wr(SR, 8'h00);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic [7:0] rst_exp [0:7];
      rst_exp = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 8; i++) begin
         rd(TB + i, d); chk($sformatf("R1 time byte %0d", i), d, rst_exp[i]);
         rd(AB + i, d); chk($sformatf("R1 alarm byte %0d", i), d, 8'h00);
      end
      rd(SR, d); chk("R1 status", d, 8'h00);
      rd(IE, d); chk("R1 int enable", d, 8'h00);
      chk("R1 alarm_flag", {7'b0, alarm_flag}, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);

      // R2 readback and weekday width
      wr(AB + 6, 8'h5A); rd(AB + 6, d); chk("R2 alarm byte 6 readback", d, 8'h5A);
      wr(TB + 6, 8'h0D); rd(TB + 6, d); chk("R2 weekday keeps bits 2:0", d, 8'h05);
      wr(AB + 6, 8'h00);

      // vector walk: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         for (int b = 0; b < 8; b++) wr(TB + b, VEC[v][127 - 8*b -: 8]);
         do_tick();
         for (int b = 0; b < 8; b++) begin
            rd(TB + b, d);
            chk($sformatf("R%0d vector %0d byte %0d", VREQ[v], v, b), d, VEC[v][63 - 8*b -: 8]);
         end
      end

      // R3 hold with no tick
      wr(TB + 0, 8'h42); wr(TB + 1, 8'h17);
      repeat (10) @(negedge clk);
      rd(TB + 0, d); chk("R3 seconds hold without tick", d, 8'h42);
      rd(TB + 1, d); chk("R3 minutes hold without tick", d, 8'h17);

      // R12 write and tick collide
      wr(TB + 0, 8'h10); wr(TB + 1, 8'h00);
      @(negedge clk);
      tick = 1'b1; reg_we = 1'b1; reg_addr = AW'(TB + 0); reg_wdata = 8'h30;
      @(negedge clk);
      tick = 1'b0; reg_we = 1'b0;
      rd(TB + 0, d); chk("R12 written seconds win over tick", d, 8'h30);
      rd(TB + 1, d); chk("R12 minutes untouched by dropped tick", d, 8'h00);

      // R9 nothing enabled never fires (alarm bytes 6,7 also set)
      wr(AB + 0, 8'h01); wr(AB + 6, 8'h00); wr(AB + 7, 8'h20);
      wr(TB + 0, 8'h00); wr(TB + 7, 8'h20);
      do_tick();
      chk("R9 no enabled field, no match", {7'b0, alarm_flag}, 8'h00);
      clear_alarm();

      // R9 single enabled field; R10 flag readable; R11 gated off
      wr(AB + 0, 8'h85); wr(TB + 0, 8'h04);
      do_tick();
      chk("R9 seconds alarm fires", {7'b0, alarm_flag}, 8'h01);
      rd(SR, d); chk("R10 status bit 5 set", d, 8'h20);
      chk("R11 irq low while disabled", {7'b0, irq}, 8'h00);
      wr(IE, 8'h20);
      rd(IE, d); chk("R11 enable readback", d, 8'h20);
      chk("R11 irq high once enabled", {7'b0, irq}, 8'h01);
      repeat (3) @(negedge clk);
      chk("R10 flag stays without tick", {7'b0, alarm_flag}, 8'h01);
      wr(SR, 8'hFF);
      chk("R10 writing 1 keeps flag", {7'b0, alarm_flag}, 8'h01);
      wr(SR, 8'h00);
      chk("R10 writing 0 clears flag", {7'b0, alarm_flag}, 8'h00);
      chk("R11 irq drops with flag", {7'b0, irq}, 8'h00);
      clear_alarm();

      // R9 two fields, mismatch then match
      wr(AB + 0, 8'h80); wr(AB + 1, 8'h82);
      wr(TB + 0, 8'h59); wr(TB + 1, 8'h00);
      do_tick();
      chk("R9 minute mismatch blocks match", {7'b0, alarm_flag}, 8'h00);
      wr(AB + 1, 8'h81);
      wr(TB + 0, 8'h59); wr(TB + 1, 8'h00);
      do_tick();
      chk("R9 sec and min both equal", {7'b0, alarm_flag}, 8'h01);
      chk("R11 irq follows flag", {7'b0, irq}, 8'h01);
      clear_alarm();

      // R9 hour field in 12-hour form, disabled month differs
      wr(AB + 0, 8'h80); wr(AB + 1, 8'h80); wr(AB + 2, 8'hB2); wr(AB + 4, 8'h05);
      wr(TB + 0, 8'h59); wr(TB + 1, 8'h59); wr(TB + 2, 8'h11); wr(TB + 4, 8'h01);
      do_tick();
      chk("R9 hour 12 PM match, month ignored", {7'b0, alarm_flag}, 8'h01);
      clear_alarm();

      // R9 time write without tick never evaluates
      wr(AB + 0, 8'h85); wr(TB + 0, 8'h05);
      repeat (4) @(negedge clk);
      chk("R9 no evaluation without tick", {7'b0, alarm_flag}, 8'h00);

      // R10 match beats clearing write in the same cycle
      wr(TB + 0, 8'h04);
      @(negedge clk);
      tick = 1'b1; reg_we = 1'b1; reg_addr = AW'(SR); reg_wdata = 8'h00;
      @(negedge clk);
      tick = 1'b0; reg_we = 1'b0;
      chk("R10 set wins over clear", {7'b0, alarm_flag}, 8'h01);
      rd(TB + 0, d); chk("R3 tick not dropped by status write", d, 8'h05);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule